// File: doc/BRIEF.md
# Multichip Interrupt Ownership Table

This block holds one chip's copy of the ownership map in a multichip interrupt controller. The space of shared interrupts is cut into blocks of 32 IDs, and each chip's entry claims a contiguous run of those blocks. A register port lets software write and read the entries, choose which chip keeps the map consistent, and read a connection status and a sticky error bit.

A lookup port takes an interrupt ID and, one cycle later, reports whether some chip owns it and which one. It also reports whether a request for that ID is accepted. A request on a local wire is accepted only when this chip is the owner. A message request is accepted when any chip owns the ID.

Only one map update may be in flight at a time. Each accepted update raises a busy flag for a fixed window. A table write that arrives while the flag is up is refused and recorded as an error.

Top module: `mc_route_table`

## Requirements
- R1: After reset every entry is invalid, the default chip is 0, the busy flag is clear, the status reads disconnected (0) and the error bit is clear.
- R2: Register addresses 0 to 15 are the per-chip entries, laid out as bit 31 = valid, bits 13:8 = block count and bits 5:0 = first block. Reads return data one cycle after the address is presented.
- R3: Address 16 holds the default chip in bits 3:0 and the read-only busy flag in bit 31. A write that is accepted to an entry or to address 16 holds busy high for exactly 8 clock edges, and then busy clears without any further action.
- R4: A write to an entry or to address 16 while busy is high is refused and leaves the stored value unchanged. It also sets the sticky error bit (status bit 1, address 17).
- R5: Writing a 1 to status bit 1 clears the error bit. Writing a 0 there leaves it as it is. A status write never starts an update.
- R6: For a lookup, the block index is the ID bits 10:5. A valid entry owns block b when first <= b < first+count. The owned flag and the owner index are registered, with a latency of one cycle.
- R7: An ID in a block that no chip owns reports owned = 0, and both wire and message requests for it are dropped (accept = 0).
- R8: wire_ok is 1 only when this chip (self_chip) owns the ID. A wire request is accepted only in that case, while a message request is accepted for an ID owned by any chip.
- R9: When several valid ranges cover one block, the lowest chip index is reported as the owner and the overlap output is 1.
- R10: Status bit 0 (connected) becomes 1 once the default chip's entry is valid and busy is low. It stays 1 during later busy windows. It returns to 0 when that entry is invalid.
- R11: A lookup presented in the same cycle as an accepted entry write is answered from the table as it stood before that write. The following lookup uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| self_chip | input | 4 | Identifier of this chip |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| lk_id | input | 11 | Shared interrupt ID to look up |
| lk_wire | input | 1 | Request arrives on a local wire |
| lk_msg | input | 1 | Request arrives as a message |
| lk_owned | output | 1 | ID lies in an owned block |
| lk_owner | output | 4 | Owning chip index |
| lk_wire_ok | output | 1 | This chip owns the ID |
| lk_accept | output | 1 | The request is accepted |
| lk_overlap | output | 1 | More than one entry claims the block |

## Verification
A table write and an ownership lookup can land on the same clock edge. The bench triggers this by driving an entry write and a lookup into a block owned only by that new entry in one cycle. It then expects the lookup to report the block as unowned, because the old table still applies. A second lookup to the same ID on the very next cycle must name the new owner. The same scoreboard also orders a refused write against the busy window by placing a second write on the edge straight after an accepted one.

// File: rtl/mcrt_pkg.sv
package mcrt_pkg;
  localparam int BLK_W      = 6;   // block index / count width
  localparam int SUB_W      = 5;   // 32 IDs per block
  localparam int ID_W       = BLK_W + SUB_W;
  localparam int CHIP_W     = 4;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 5;

  // register field positions
  localparam int ENT_VALID_BIT = 31;
  localparam int ENT_CNT_LSB   = 8;
  localparam int ENT_FIRST_LSB = 0;
  localparam int DFLT_BUSY_BIT = 31;
  localparam int STAT_CONN_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;

  typedef struct packed {
    logic             valid;
    logic [BLK_W-1:0] count;
    logic [BLK_W-1:0] first;
  } entry_t;
endpackage

// File: rtl/mcrt_regs.sv
module mcrt_regs
  import mcrt_pkg::*;
#(
  parameter int NUM_CHIPS  = 16,
  parameter int PUP_CYCLES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output entry_t [NUM_CHIPS-1:0]     tbl
);
  localparam int CW        = $clog2(NUM_CHIPS);
  localparam int CNT_W     = $clog2(PUP_CYCLES + 1);
  localparam logic [ADDR_W-1:0] ADDR_DFLT = ADDR_W'(NUM_CHIPS);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(NUM_CHIPS + 1);

  logic [CNT_W-1:0] busy_cnt;
  logic [CW-1:0]    dflt_chip;
  logic             busy, sticky_err, connected;
  logic             hit_ent, hit_dflt, tbl_op, take, refuse;
  entry_t           wentry;

  assign busy     = (busy_cnt != '0);
  assign hit_ent  = we && (addr < ADDR_W'(NUM_CHIPS));
  assign hit_dflt = we && (addr == ADDR_DFLT);
  assign tbl_op   = hit_ent || hit_dflt;
  assign take     = tbl_op && !busy;
  assign refuse   = tbl_op && busy;

  assign wentry.valid = wdata[ENT_VALID_BIT];
  assign wentry.count = wdata[ENT_CNT_LSB +: BLK_W];
  assign wentry.first = wdata[ENT_FIRST_LSB +: BLK_W];

  logic unused_wdata;
  assign unused_wdata = ^{wdata};

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        tbl[i] <= '0;
      else if (take && hit_ent && addr[CW-1:0] == CW'(i))
        tbl[i] <= wentry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dflt_chip  <= '0;
      busy_cnt   <= '0;
      sticky_err <= 1'b0;
      connected  <= 1'b0;
    end else begin
      if (take && hit_dflt)
        dflt_chip <= wdata[CW-1:0];

      if (take)
        busy_cnt <= CNT_W'(PUP_CYCLES);
      else if (busy)
        busy_cnt <= busy_cnt - CNT_W'(1);

      if (refuse)
        sticky_err <= 1'b1;
      else if (we && addr == ADDR_STAT && wdata[STAT_ERR_BIT])
        sticky_err <= 1'b0;

      if (!tbl[dflt_chip].valid)
        connected <= 1'b0;
      else if (!busy)
        connected <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else begin
      rdata <= '0;
      if (addr < ADDR_W'(NUM_CHIPS)) begin
        rdata[ENT_VALID_BIT]              <= tbl[addr[CW-1:0]].valid;
        rdata[ENT_CNT_LSB +: BLK_W]       <= tbl[addr[CW-1:0]].count;
        rdata[ENT_FIRST_LSB +: BLK_W]     <= tbl[addr[CW-1:0]].first;
      end else if (addr == ADDR_DFLT) begin
        rdata[CW-1:0]        <= dflt_chip;
        rdata[DFLT_BUSY_BIT] <= busy;
      end else if (addr == ADDR_STAT) begin
        rdata[STAT_CONN_BIT] <= connected;
        rdata[STAT_ERR_BIT]  <= sticky_err;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (busy_cnt == '0 && !connected && !sticky_err && dflt_chip == '0));

  assert_busy_starts_R3: assert property (@(posedge clk) disable iff (rst)
    take |=> busy);

  assert_refused_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (hit_ent && busy) |=> (tbl == $past(tbl)));

  assert_refused_flags_R4: assert property (@(posedge clk) disable iff (rst)
    refuse |=> sticky_err);

  assert_connect_after_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(connected) |-> $past(!busy));
endmodule

// File: rtl/mcrt_lookup.sv
module mcrt_lookup
  import mcrt_pkg::*;
#(
  parameter int NUM_CHIPS = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  entry_t [NUM_CHIPS-1:0] tbl,
  input  logic [CHIP_W-1:0]      self_chip,
  input  logic [ID_W-1:0]        id,
  input  logic                   wire_req,
  input  logic                   msg_req,
  output logic                   owned,
  output logic [CHIP_W-1:0]      owner,
  output logic                   wire_ok,
  output logic                   accept,
  output logic                   overlap
);
  logic [BLK_W-1:0]     blk;
  logic [NUM_CHIPS-1:0] hit;
  logic [CHIP_W-1:0]    win;
  logic                 any_hit, multi, is_self;

  assign blk = id[ID_W-1:SUB_W];

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_match
    logic [BLK_W:0] lim;
    assign lim    = {1'b0, tbl[i].first} + {1'b0, tbl[i].count};
    assign hit[i] = tbl[i].valid && (blk >= tbl[i].first) && ({1'b0, blk} < lim);
  end

  always_comb begin
    win = '0;
    for (int i = NUM_CHIPS - 1; i >= 0; i--)
      if (hit[i]) win = CHIP_W'(i);
  end

  assign any_hit = |hit;
  assign multi   = (hit & (hit - NUM_CHIPS'(1))) != '0;
  assign is_self = any_hit && (win == self_chip);

  always_ff @(posedge clk) begin
    if (rst) begin
      owned   <= 1'b0;
      owner   <= '0;
      wire_ok <= 1'b0;
      accept  <= 1'b0;
      overlap <= 1'b0;
    end else begin
      owned   <= any_hit;
      owner   <= win;
      wire_ok <= is_self;
      accept  <= (any_hit && msg_req) || (is_self && wire_req);
      overlap <= multi;
    end
  end

  assert_unowned_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    !owned |-> (!accept && !wire_ok));

  assert_wire_local_only_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && !$past(msg_req)) |-> wire_ok);

  assert_overlap_owned_R9: assert property (@(posedge clk) disable iff (rst)
    overlap |-> owned);
endmodule

// File: rtl/mc_route_table.sv
module mc_route_table
  import mcrt_pkg::*;
#(
  parameter int NUM_CHIPS  = 16,
  parameter int PUP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        self_chip,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [10:0]       lk_id,
  input  logic              lk_wire,
  input  logic              lk_msg,
  output logic              lk_owned,
  output logic [3:0]        lk_owner,
  output logic              lk_wire_ok,
  output logic              lk_accept,
  output logic              lk_overlap
);
  entry_t [NUM_CHIPS-1:0] tbl;

  mcrt_regs #(.NUM_CHIPS(NUM_CHIPS), .PUP_CYCLES(PUP_CYCLES)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .tbl(tbl)
  );

  mcrt_lookup #(.NUM_CHIPS(NUM_CHIPS)) u_lookup (
    .clk(clk), .rst(rst), .tbl(tbl), .self_chip(self_chip),
    .id(lk_id), .wire_req(lk_wire), .msg_req(lk_msg),
    .owned(lk_owned), .owner(lk_owner), .wire_ok(lk_wire_ok),
    .accept(lk_accept), .overlap(lk_overlap)
  );
endmodule

// File: tb/tb_mc_route_table.sv
module tb_mc_route_table;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  self_chip = 4'd3;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [10:0] lk_id = '0;
  logic        lk_wire = 1'b0, lk_msg = 1'b0;
  logic        lk_owned, lk_wire_ok, lk_accept, lk_overlap;
  logic [3:0]  lk_owner;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  mc_route_table dut (
    .clk(clk), .rst(rst), .self_chip(self_chip), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_id(lk_id), .lk_wire(lk_wire), .lk_msg(lk_msg),
    .lk_owned(lk_owned), .lk_owner(lk_owner), .lk_wire_ok(lk_wire_ok),
    .lk_accept(lk_accept), .lk_overlap(lk_overlap)
  );

  // scoreboard queues
  logic [31:0] rd_exp[$];
  string       rd_tag[$];
  logic [7:0]  lk_exp[$];
  string       lk_tag[$];
  logic rd_req = 0, rd_req_d = 0, lk_req = 0, lk_req_d = 0;

  always @(posedge clk) begin
    rd_req_d <= rd_req;
    lk_req_d <= lk_req;
  end

  always @(negedge clk) begin
    if (rd_req_d) begin
      logic [31:0] e; string t;
      e = rd_exp.pop_front(); t = rd_tag.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
      end
    end
    if (lk_req_d) begin
      logic [7:0] e, a; string t;
      e = lk_exp.pop_front(); t = lk_tag.pop_front();
      a = {lk_owned, lk_owner, lk_wire_ok, lk_accept, lk_overlap};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: lookup {own,owner,wok,acc,ovl} actual %b expected %b", t, a, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    reg_addr = a; rd_req = 1; rd_exp.push_back(e); rd_tag.push_back(t);
    tick();
    rd_req = 0;
  endtask

  task automatic push_lk(input logic [10:0] id, input logic w, input logic m,
                         input logic own, input logic [3:0] who, input logic wok,
                         input logic acc, input logic ovl, input string t);
    lk_id = id; lk_wire = w; lk_msg = m; lk_req = 1;
    lk_exp.push_back({own, who, wok, acc, ovl}); lk_tag.push_back(t);
  endtask

  task automatic lk(input logic [10:0] id, input logic w, input logic m,
                    input logic own, input logic [3:0] who, input logic wok,
                    input logic acc, input logic ovl, input string t);
    push_lk(id, w, m, own, who, wok, acc, ovl, t);
    tick();
    lk_req = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(5'd0,  32'h0, "R1 entry0");
    rd(5'd16, 32'h0, "R1 default/busy");
    rd(5'd17, 32'h0, "R1 status");
    lk(11'd64, 1, 1, 0, 0, 0, 0, 0, "R1 R7 empty table");

    // R2/R3: entry3 owns blocks 2..4, busy exactly 8 edges
    wr(5'd3, 32'h8000_0302);
    rd(5'd16, 32'h8000_0000, "R3 busy after write");
    repeat (6) tick();
    rd(5'd16, 32'h8000_0000, "R3 busy on 8th edge");
    rd(5'd16, 32'h0, "R3 busy cleared on 9th edge");
    rd(5'd3,  32'h8000_0302, "R2 entry3 readback");

    // R6/R7/R8 lookups
    lk(11'd64,  1, 0, 1, 4'd3, 1, 1, 0, "R6 R8 block2 first");
    lk(11'd159, 1, 0, 1, 4'd3, 1, 1, 0, "R6 block4 last id");
    lk(11'd160, 1, 1, 0, 4'd0, 0, 0, 0, "R7 block5 past range");
    lk(11'd63,  0, 1, 0, 4'd0, 0, 0, 0, "R7 block1 below range");

    // R9 overlap: entry5 owns blocks 4,5
    wr(5'd5, 32'h8000_0204);
    repeat (9) tick();
    lk(11'd130, 1, 0, 1, 4'd3, 1, 1, 1, "R9 overlap lowest wins");
    lk(11'd170, 1, 0, 1, 4'd5, 0, 0, 0, "R8 remote wire dropped");
    lk(11'd170, 0, 1, 1, 4'd5, 0, 1, 0, "R8 remote message accepted");

    // R4 refused writes while busy
    wr(5'd6, 32'h8000_010A);
    wr(5'd6, 32'h8000_0114);
    wr(5'd16, 32'h0000_0005);
    repeat (9) tick();
    rd(5'd6,  32'h8000_010A, "R4 entry kept");
    rd(5'd16, 32'h0, "R4 default kept");
    rd(5'd17, 32'h2, "R4 sticky error");

    // R5 W1C
    wr(5'd17, 32'h0);
    rd(5'd17, 32'h2, "R5 write 0 keeps error");
    wr(5'd17, 32'h2);
    rd(5'd17, 32'h0, "R5 write 1 clears error");
    rd(5'd16, 32'h0, "R5 status write not busy");

    // R10 connection
    wr(5'd16, 32'h3);
    rd(5'd16, 32'h8000_0003, "R3 default chip with busy");
    rd(5'd17, 32'h0, "R10 not connected while busy");
    repeat (11) tick();
    rd(5'd17, 32'h1, "R10 connected");
    wr(5'd3, 32'h0);
    repeat (10) tick();
    rd(5'd17, 32'h0, "R10 disconnected after invalidate");

    // R11 simultaneous write and lookup
    reg_we = 1; reg_addr = 5'd3; reg_wdata = 32'h8000_0302;
    push_lk(11'd64, 1, 0, 0, 4'd0, 0, 0, 0, "R11 lookup sees old table");
    tick();
    reg_we = 0;
    lk(11'd64, 1, 0, 1, 4'd3, 1, 1, 0, "R11 next lookup sees new table");
    lk_req = 0;
    repeat (2) tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule